// File: doc/BRIEF.md
# Scalar rounding and saturating shifter

This block runs four single-register shift-by-immediate operations on a 32-bit value. The four are a rounding right shift (signed or unsigned) and a saturating left shift (signed or unsigned). It receives a 32-bit instruction word together with the current contents of the register that the word names. It decodes the word and computes the shifted value. One cycle later it presents a result, a write strobe and the destination index, or it raises an undefined-instruction flag. A sticky saturation flag records every clamp made by a left shift. Software clears that flag through a dedicated synchronous input.

A small two-state machine sequences the block. It sits in `ST_IDLE` until a recognised instruction arrives with `in_valid`. That input moves it to `ST_DONE` for exactly one cycle (transition IDLE->DONE). In `ST_DONE` the outputs are presented. The machine then returns to `ST_IDLE` (transition DONE->IDLE), or stays in `ST_DONE` if another recognised instruction arrives in the same cycle (transition DONE->DONE). Words that do not match the encoding leave the machine in, or return it to, `ST_IDLE` (transition IDLE->IDLE).

Top module: `rsh_scalar_shifter`

## Requirements
- R1: A word is recognised only when bits [31:20] = 0xEA5, bit 15 = 0, bits [11:8] = 0xF and bits [3:0] = 0xF. Any other word produces no `out_valid`, no `out_we` and no `out_undef`.
- R2: Bits [5:4] select the operation: 00 unsigned saturating left, 01 unsigned rounding right, 10 signed rounding right, 11 signed saturating left.
- R3: The shift amount is {bits[14:12], bits[7:6]}, with bits [14:12] as the high part. An encoded value of 0 means a shift by 32.
- R4: An unsigned rounding right shift by n in 1..31 returns (x >> n) + x[n-1], using a logical shift.
- R5: A signed rounding right shift by n in 1..31 returns (x >>> n) + x[n-1], using an arithmetic shift.
- R6: A rounding right shift by 32 returns 0 in the signed form. In the unsigned form it returns x[31] as the value 0 or 1.
- R7: An unsigned saturating left shift returns x << n when no set bit leaves bit 31. Otherwise it returns 0xFFFFFFFF and sets the saturation flag. A shift by 32 of any nonzero value saturates.
- R8: A signed saturating left shift returns x << n when the result keeps the sign. Otherwise it returns 0x7FFFFFFF for a non-negative x or 0x80000000 for a negative x, and sets the saturation flag.
- R9: The saturation flag stays set until `sat_clr` is sampled high. If a saturating operation and `sat_clr` arrive in the same cycle, the flag ends up set.
- R10: A register index (bits [19:16]) of 13 or 15 gives `out_undef` = 1 and `out_we` = 0, and leaves the saturation flag unchanged.
- R11: Outputs appear exactly one cycle after the accepting edge and last one cycle. `out_rd` carries bits [19:16].
- R12: After reset, `out_valid`, `out_we`, `out_undef`, `out_result` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operand are present |
| in_insn | input | 32 | Instruction word to decode |
| in_rdata | input | 32 | Current value of the addressed register |
| sat_clr | input | 1 | Synchronous clear of the saturation flag |
| out_valid | output | 1 | A recognised instruction completed |
| out_we | output | 1 | Write `out_result` to register `out_rd` |
| out_undef | output | 1 | Instruction is undefined (bad register index) |
| out_rd | output | 4 | Destination register index |
| out_result | output | 32 | Shifted value |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A saturating left shift can set the sticky flag in the same cycle that `sat_clr` tries to clear it. The bench provokes this by issuing a clamping shift with `sat_clr` held high. It then checks that the flag reads 1 on the following cycle, and that a later lone `sat_clr` brings it to 0. A further case sends a clamping shift to register 13 or 15. The flag must then stay unchanged while `out_undef` rises and `out_we` stays low.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

    localparam int INSN_W = 32;
    localparam int RIDX_W = 4;
    localparam int AMT_W  = 6;

    typedef enum logic [1:0] {
        OP_UQSHL = 2'b00,
        OP_URSHR = 2'b01,
        OP_SRSHR = 2'b10,
        OP_SQSHL = 2'b11
    } shop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } st_e;

    typedef struct packed {
        logic              match;
        logic              bad_reg;
        shop_e             op;
        logic [RIDX_W-1:0] rd;
        logic [AMT_W-1:0]  amt;
    } dec_s;

endpackage

// File: rtl/rsh_decode.sv
module rsh_decode
    import rsh_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_s              dec
);

    logic [4:0] imm;

    always_comb begin
        imm         = {insn[14:12], insn[7:6]};
        dec.match   = (insn[31:20] == 12'hEA5) && !insn[15] &&
                      (insn[11:8] == 4'hF) && (insn[3:0] == 4'hF);
        dec.rd      = insn[19:16];
        dec.bad_reg = (insn[19:16] == 4'd13) || (insn[19:16] == 4'd15);
        dec.op      = shop_e'(insn[5:4]);
        dec.amt     = (imm == 5'd0) ? AMT_W'(32) : AMT_W'(imm);
    end

endmodule

// File: rtl/rsh_round_right.sv
module rsh_round_right #(
    parameter int XLEN  = 32,
    parameter int AMT_W = 6
) (
    input  logic [XLEN-1:0]  x,
    input  logic [AMT_W-1:0] amt,
    input  logic             is_signed,
    output logic [XLEN-1:0]  res
);

    logic [XLEN-1:0]  shifted;
    logic [AMT_W-1:0] amt_m1;
    logic             rbit;

    always_comb begin
        amt_m1  = amt - AMT_W'(1);
        rbit    = 1'b0;
        shifted = '0;
        if (int'(amt) >= XLEN) begin
            res = is_signed ? '0 : XLEN'(x[XLEN-1]);
        end else begin
            if (amt != '0) begin
                rbit = |((x >> amt_m1) & XLEN'(1));
            end
            if (is_signed) begin
                shifted = XLEN'($signed(x) >>> amt);
            end else begin
                shifted = x >> amt;
            end
            res = shifted + XLEN'(rbit);
        end
    end

endmodule

// File: rtl/rsh_sat_left.sv
module rsh_sat_left #(
    parameter int XLEN  = 32,
    parameter int AMT_W = 6
) (
    input  logic [XLEN-1:0]  x,
    input  logic [AMT_W-1:0] amt,
    input  logic             is_signed,
    output logic [XLEN-1:0]  res,
    output logic             sat
);

    localparam int WW = 2 * XLEN;

    logic [WW-1:0]   wide;
    logic [WW-1:0]   prod;
    logic [XLEN-1:0] clamp;

    always_comb begin
        wide = is_signed ? {{XLEN{x[XLEN-1]}}, x} : {{XLEN{1'b0}}, x};
        prod = wide << amt;
        if (is_signed) begin
            sat   = prod[WW-1:XLEN-1] != {(XLEN+1){x[XLEN-1]}};
            clamp = x[XLEN-1] ? {1'b1, {(XLEN-1){1'b0}}} : {1'b0, {(XLEN-1){1'b1}}};
        end else begin
            sat   = |prod[WW-1:XLEN];
            clamp = '1;
        end
        res = sat ? clamp : prod[XLEN-1:0];
    end

    // An unclamped result must shift back to the exact input.
    always_comb begin
        if (!sat && int'(amt) < XLEN) begin
            // R7 R8
            lossless_chk: assert (is_signed ? (XLEN'($signed(res) >>> amt) == x)
                                            : ((res >> amt) == x));
        end
    end

endmodule

// File: rtl/rsh_scalar_shifter.sv
module rsh_scalar_shifter
    import rsh_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [XLEN-1:0]   in_rdata,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic              out_we,
    output logic              out_undef,
    output logic [3:0]        out_rd,
    output logic [XLEN-1:0]   out_result,
    output logic              sat_flag
);

    dec_s            dec;
    logic [XLEN-1:0] rr_res;
    logic [XLEN-1:0] sl_res;
    logic            sl_sat;
    logic [XLEN-1:0] nxt_result;
    logic            is_left;
    logic            accept;
    logic            legal;
    logic            sat_set;

    st_e               state_q;
    logic              undef_q;
    logic [RIDX_W-1:0] rd_q;
    logic [XLEN-1:0]   res_q;

    rsh_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    rsh_round_right #(.XLEN(XLEN), .AMT_W(AMT_W)) u_rr (
        .x         (in_rdata),
        .amt       (dec.amt),
        .is_signed (dec.op == OP_SRSHR),
        .res       (rr_res)
    );

    rsh_sat_left #(.XLEN(XLEN), .AMT_W(AMT_W)) u_sl (
        .x         (in_rdata),
        .amt       (dec.amt),
        .is_signed (dec.op == OP_SQSHL),
        .res       (sl_res),
        .sat       (sl_sat)
    );

    always_comb begin
        unique case (dec.op)
            OP_UQSHL, OP_SQSHL: begin
                nxt_result = sl_res;
                is_left    = 1'b1;
            end
            OP_URSHR, OP_SRSHR: begin
                nxt_result = rr_res;
                is_left    = 1'b0;
            end
            default: begin
                nxt_result = '0;
                is_left    = 1'b0;
            end
        endcase
        accept  = in_valid && dec.match;
        legal   = accept && !dec.bad_reg;
        sat_set = legal && is_left && sl_sat;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= accept ? ST_DONE : ST_IDLE;
                ST_DONE: state_q <= accept ? ST_DONE : ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Payload and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            undef_q  <= 1'b0;
            rd_q     <= '0;
            res_q    <= '0;
            sat_flag <= 1'b0;
        end else begin
            if (accept) begin
                undef_q <= dec.bad_reg;
                rd_q    <= dec.rd;
                res_q   <= dec.bad_reg ? '0 : nxt_result;
            end
            if (sat_set) begin
                sat_flag <= 1'b1;
            end else if (sat_clr) begin
                sat_flag <= 1'b0;
            end
        end
    end

    // Outputs from state
    always_comb begin
        out_rd     = rd_q;
        out_result = res_q;
        unique case (state_q)
            ST_DONE: begin
                out_valid = 1'b1;
                out_we    = !undef_q;
                out_undef = undef_q;
            end
            default: begin
                out_valid = 1'b0;
                out_we    = 1'b0;
                out_undef = 1'b0;
            end
        endcase
    end

    // R11
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.match) |=> (out_valid && out_rd == $past(in_insn[19:16])));

    // R1
    nomatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && dec.match) |=> (!out_valid && !out_we && !out_undef));

    // R10
    undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.match && dec.bad_reg) |=> (out_undef && !out_we));

    // R10
    undef_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.match && dec.bad_reg && !sat_clr) |=> $stable(sat_flag));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !(in_valid && dec.match && !dec.bad_reg && sl_sat &&
                      (dec.op == OP_UQSHL || dec.op == OP_SQSHL))) |=> !sat_flag);

endmodule

// File: tb/sim_rsh_scalar_shifter.sv
`timescale 1ns/1ps
module sim_rsh_scalar_shifter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_insn;
    logic [31:0] in_rdata;
    logic        sat_clr;
    logic        out_valid, out_we, out_undef, sat_flag;
    logic [3:0]  out_rd;
    logic [31:0] out_result;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rsh_scalar_shifter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_rdata(in_rdata), .sat_clr(sat_clr), .out_valid(out_valid),
        .out_we(out_we), .out_undef(out_undef), .out_rd(out_rd),
        .out_result(out_result), .sat_flag(sat_flag)
    );

    // {op[1:0], imm[4:0], x[31:0], expected[31:0], expected_sat}
    localparam int NV = 20;
    localparam logic [71:0] VEC [NV] = '{
        {2'd1, 5'd4,  32'h0000_0018, 32'h0000_0002, 1'b0},
        {2'd1, 5'd4,  32'h0000_0017, 32'h0000_0001, 1'b0},
        {2'd1, 5'd0,  32'h8000_0000, 32'h0000_0001, 1'b0},
        {2'd1, 5'd0,  32'h7FFF_FFFF, 32'h0000_0000, 1'b0},
        {2'd1, 5'd31, 32'hC000_0000, 32'h0000_0002, 1'b0},
        {2'd2, 5'd1,  32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
        {2'd2, 5'd4,  32'hFFFF_FFE8, 32'hFFFF_FFFF, 1'b0},
        {2'd2, 5'd0,  32'h8000_0000, 32'h0000_0000, 1'b0},
        {2'd2, 5'd8,  32'h0000_1280, 32'h0000_0013, 1'b0},
        {2'd0, 5'd4,  32'h0FFF_FFFF, 32'hFFFF_FFF0, 1'b0},
        {2'd0, 5'd4,  32'h1000_0000, 32'hFFFF_FFFF, 1'b1},
        {2'd0, 5'd0,  32'h0000_0000, 32'h0000_0000, 1'b0},
        {2'd0, 5'd0,  32'h0000_0001, 32'hFFFF_FFFF, 1'b1},
        {2'd3, 5'd1,  32'h3FFF_FFFF, 32'h7FFF_FFFE, 1'b0},
        {2'd3, 5'd1,  32'h4000_0000, 32'h7FFF_FFFF, 1'b1},
        {2'd3, 5'd2,  32'hE000_0000, 32'h8000_0000, 1'b0},
        {2'd3, 5'd3,  32'hE000_0000, 32'h8000_0000, 1'b1},
        {2'd3, 5'd0,  32'hFFFF_FFFF, 32'h8000_0000, 1'b1},
        {2'd3, 5'd0,  32'h0000_0000, 32'h0000_0000, 1'b0},
        {2'd0, 5'd31, 32'h0000_0001, 32'h8000_0000, 1'b0}
    };

    function automatic logic [31:0] mk(logic [1:0] op, logic [3:0] rd, logic [4:0] n);
        return {12'hEA5, rd, 1'b0, n[4:2], 4'hF, n[1:0], op, 4'hF};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle (caller is at a falling edge); returns at the next falling edge.
    task automatic step(logic v, logic [31:0] insn, logic [31:0] x, logic clr);
        in_valid = v;
        in_insn  = insn;
        in_rdata = x;
        sat_clr  = clr;
        @(negedge clk);
        in_valid = 1'b0;
        sat_clr  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_rdata = '0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 valid", 32'(out_valid), 0);
        chk("R12 we", 32'(out_we), 0);
        chk("R12 undef", 32'(out_undef), 0);
        chk("R12 result", out_result, 0);
        chk("R12 sat", 32'(sat_flag), 0);

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            step(1'b0, '0, '0, 1'b1);
            step(1'b1, mk(VEC[i][71:70], 4'd3, VEC[i][69:65]), VEC[i][64:33], 1'b0);
            chk($sformatf("R2 R3 R4 R5 R6 valid vec%0d", i), 32'(out_valid & out_we), 1);
            chk($sformatf("R4 R5 R6 R7 R8 result vec%0d", i), out_result, VEC[i][32:1]);
            chk($sformatf("R7 R8 sat vec%0d", i), 32'(sat_flag), 32'(VEC[i][0]));
        end

        // R10: bad register index, clamping operand, flag must stay clear
        step(1'b0, '0, '0, 1'b1);
        step(1'b1, mk(2'd0, 4'd13, 5'd4), 32'h1000_0000, 1'b0);
        chk("R10 rd13 undef", 32'(out_valid & out_undef), 1);
        chk("R10 rd13 we", 32'(out_we), 0);
        chk("R10 rd13 sat", 32'(sat_flag), 0);
        step(1'b1, mk(2'd3, 4'd15, 5'd1), 32'h4000_0000, 1'b0);
        chk("R10 rd15 undef", 32'(out_undef), 1);
        chk("R10 rd15 we", 32'(out_we), 0);
        chk("R10 rd15 sat", 32'(sat_flag), 0);

        // R1: non-matching words
        step(1'b1, mk(2'd1, 4'd2, 5'd4) | 32'h0000_8000, 32'h18, 1'b0);
        chk("R1 bit15 quiet", {29'd0, out_valid, out_we, out_undef}, 0);
        step(1'b1, mk(2'd1, 4'd2, 5'd4) & 32'hFFFF_FFFE, 32'h18, 1'b0);
        chk("R1 low nibble quiet", {29'd0, out_valid, out_we, out_undef}, 0);
        step(1'b1, mk(2'd1, 4'd2, 5'd4) ^ 32'h0010_0000, 32'h18, 1'b0);
        chk("R1 top field quiet", {29'd0, out_valid, out_we, out_undef}, 0);

        // R11: destination index and one-cycle output
        step(1'b1, mk(2'd1, 4'd7, 5'd4), 32'h18, 1'b0);
        chk("R11 rd", 32'(out_rd), 7);
        chk("R11 result", out_result, 2);
        step(1'b0, '0, '0, 1'b0);
        chk("R11 single cycle", 32'(out_valid), 0);

        // R9: sticky flag, set beats clear
        step(1'b1, mk(2'd0, 4'd1, 5'd4), 32'h1000_0000, 1'b0);
        chk("R9 set", 32'(sat_flag), 1);
        step(1'b1, mk(2'd1, 4'd1, 5'd4), 32'h18, 1'b0);
        chk("R9 sticky", 32'(sat_flag), 1);
        step(1'b1, mk(2'd3, 4'd1, 5'd1), 32'h4000_0000, 1'b1);
        chk("R9 set wins over clear", 32'(sat_flag), 1);
        step(1'b0, '0, '0, 1'b1);
        chk("R9 clear", 32'(sat_flag), 0);
        step(1'b0, '0, '0, 1'b0);
        chk("R9 stays clear", 32'(sat_flag), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule